// File: doc/BRIEF.md
# SECDED-Protected Simple Dual-Port RAM

This block is a 512-word memory with one write port and one read port, each on its own clock. Every word carries 64 data bits and is guarded by an extended Hamming code. On a write the block derives eight check bits from the incoming data and stores them next to it, giving a 72-bit stored word. The same check bits are returned on the write side one write-clock edge later.

On a read the whole 72-bit word goes through a syndrome decoder. A single flipped bit is repaired in the returned data. Two flipped bits are reported but left uncorrected. Two status flags distinguish a clean read, a corrected read and a detected double fault. The stored copy is never repaired, so a faulty word reports the same result on every read.

A parameter adds one register stage after the decoder, placed on the data and on both flags, to shorten the read-side timing path. For test, a mask input flips chosen stored bits during a write, so that faults can be placed at known positions.

Top module: `secded_sdp_ram`

## Requirements
- R1: A write with `wr_en` high at a `wr_clk` edge stores the word at `wr_addr`. Bits [63:0] hold the data and bits [71:64] hold the check bits, with the overall parity bit at bit 71. The stored word is XORed with `wr_inj`, and the mask never affects `wr_chk`.
- R2: Each data bit j is placed at a codeword position. Positions are taken in ascending order from 3 upwards, skipping powers of two, so data bit 0 sits at position 3. Check bit i (i < 7) is the XOR of the data bits whose position has bit i set. Check bit 7 makes the XOR over all 72 bits zero. `wr_chk` is updated with these bits at every write edge and holds when `wr_en` is low.
- R3: Reading a word with no flipped bit returns the written data with `rd_sbe` = 0 and `rd_dbe` = 0.
- R4: Reading a word with one flipped data bit returns the original data with `rd_sbe` = 1 and `rd_dbe` = 0.
- R5: Reading a word with one flipped check bit, including bit 71, returns the stored data unchanged with `rd_sbe` = 1 and `rd_dbe` = 0.
- R6: Reading a word with two flipped bits gives `rd_dbe` = 1 and `rd_sbe` = 0. The returned data is then the raw stored data bits, without correction.
- R7: A read never changes the stored word. Reading the same address again returns the same data and flags.
- R8: The outputs change one `rd_clk` edge after an edge with `rd_en` high when `OUT_REG` = 0, and two edges after when `OUT_REG` = 1. While `rd_en` stays low, the outputs hold their values.
- R9: While a reset is asserted, `wr_chk`, `rd_data`, `rd_sbe` and `rd_dbe` are all zero.
- R10: `rd_sbe` and `rd_dbe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write address |
| wr_data | input | 64 | Write data |
| wr_inj | input | 72 | Test mask XORed into the stored word |
| wr_chk | output | 8 | Check bits of the last write |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 9 | Read address |
| rd_data | output | 64 | Corrected read data |
| rd_sbe | output | 1 | Single error seen and corrected |
| rd_dbe | output | 1 | Double error detected |

## Verification
The checks assume that no read and write hit the same address on the same edge. They also assume that every address is written before it is first read, since the storage has no reset. The stimulus writes all table entries before any read and only reads addresses it has already written. Fault masks flip at most two bits, because the code does not classify three or more flips reliably. The reset-state checks are made only while both resets are held.

// File: rtl/secded_pkg.sv
package secded_pkg;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Hamming check bits needed for dw data bits (overall parity excluded)
  function automatic int hamming_bits(input int dw);
    int p;
    p = 1;
    for (int k = 0; k < 16; k++)
      if ((1 << p) < dw + p + 1) p = p + 1;
    return p;
  endfunction

  // Codeword position of data bit j: ascending, powers of two skipped
  function automatic int code_pos(input int j);
    int cnt;
    int res;
    cnt = -1;
    res = 0;
    for (int q = 1; q < 1024; q++) begin
      if (!is_pow2(q)) begin
        cnt = cnt + 1;
        if (cnt == j) res = q;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W:0]    chk_o
);

  logic [HAM_W-1:0] ham;

  always_comb begin
    ham = '0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int i = 0; i < HAM_W; i++) begin
        if (code_pos(j) & (1 << i)) ham[i] = ham[i] ^ data_i[j];
      end
    end
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7,
  localparam int CODE_W = DATA_W + HAM_W + 1
) (
  input  logic [CODE_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sbe_o,
  output logic              dbe_o
);

  logic [DATA_W-1:0] raw_d;
  logic [HAM_W-1:0]  syn;
  logic              odd;

  assign raw_d = word_i[DATA_W-1:0];
  assign odd   = ^word_i;

  always_comb begin
    syn = word_i[DATA_W+HAM_W-1:DATA_W];
    for (int j = 0; j < DATA_W; j++) begin
      if (raw_d[j]) syn = syn ^ HAM_W'(code_pos(j));
    end
  end

  assign sbe_o = odd;
  assign dbe_o = !odd && (syn != '0);

  always_comb begin
    for (int j = 0; j < DATA_W; j++) begin
      data_o[j] = raw_d[j] ^ (odd && (code_pos(j) == int'(syn)));
    end
  end

endmodule

// File: rtl/sdp_array.sv
module sdp_array #(
  parameter int DEPTH  = 512,
  parameter int WORD_W = 72,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_flip,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_word ^ wr_flip;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n)  rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_addr];
  end

endmodule

// File: rtl/secded_sdp_ram.sv
module secded_sdp_ram
  import secded_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 512,
  parameter bit OUT_REG = 1'b1,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int HAM_W  = hamming_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1,
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CODE_W-1:0] wr_inj,
  output logic [CHK_W-1:0]  wr_chk,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sbe,
  output logic              rd_dbe
);

  // Named internal events, observed by the bound checker
  logic [CHK_W-1:0]  enc_chk;
  logic [CODE_W-1:0] raw_word;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sbe;
  logic              dec_dbe;

  secded_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .data_i (wr_data),
    .chk_o  (enc_chk)
  );

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n)  wr_chk <= '0;
    else if (wr_en) wr_chk <= enc_chk;
  end

  sdp_array #(.DEPTH(DEPTH), .WORD_W(CODE_W)) u_arr (
    .wr_clk   (wr_clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_word  ({enc_chk, wr_data}),
    .wr_flip  (wr_inj),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_word  (raw_word)
  );

  secded_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
    .word_i (raw_word),
    .data_o (dec_data),
    .sbe_o  (dec_sbe),
    .dbe_o  (dec_dbe)
  );

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
          rd_data <= '0;
          rd_sbe  <= 1'b0;
          rd_dbe  <= 1'b0;
        end else begin
          rd_data <= dec_data;
          rd_sbe  <= dec_sbe;
          rd_dbe  <= dec_dbe;
        end
      end
    end else begin : g_comb
      assign rd_data = dec_data;
      assign rd_sbe  = dec_sbe;
      assign rd_dbe  = dec_dbe;
    end
  endgenerate

endmodule

// File: rtl/secded_sdp_ram_chk.sv
module secded_sdp_ram_chk #(
  parameter int DATA_W  = 64,
  parameter int CHK_W   = 8,
  parameter int CODE_W  = 72,
  parameter bit OUT_REG = 1'b1
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [CHK_W-1:0]  wr_chk,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_en,
  input logic [CODE_W-1:0] raw_word,
  input logic [DATA_W-1:0] dec_data,
  input logic              dec_sbe,
  input logic              dec_dbe,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_sbe,
  input logic              rd_dbe
);

  // R10
  flags_exclusive_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_sbe && rd_dbe));

  // R2
  wr_chk_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_en |=> $stable(wr_chk));

  // R2
  wr_parity_even_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_en |=> (((^wr_chk) ^ (^$past(wr_data))) == 1'b0));

  // R3
  clean_pass_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!dec_sbe && !dec_dbe) |-> (dec_data == raw_word[DATA_W-1:0]));

  // R6
  double_raw_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    dec_dbe |-> (dec_data == raw_word[DATA_W-1:0]));

  // R8
  read_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(raw_word));

  generate
    if (OUT_REG) begin : g_oreg_chk
      // R8
      out_stage_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        1'b1 |=> ({rd_data, rd_sbe, rd_dbe} == $past({dec_data, dec_sbe, dec_dbe})));
    end
  endgenerate

endmodule

bind secded_sdp_ram secded_sdp_ram_chk #(
  .DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W), .OUT_REG(OUT_REG)
) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .wr_chk   (wr_chk),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .rd_en    (rd_en),
  .raw_word (raw_word),
  .dec_data (dec_data),
  .dec_sbe  (dec_sbe),
  .dec_dbe  (dec_dbe),
  .rd_data  (rd_data),
  .rd_sbe   (rd_sbe),
  .rd_dbe   (rd_dbe)
);

// File: tb/secded_sdp_ram_bench.sv
module secded_sdp_ram_bench;

  typedef struct packed {
    logic [8:0]  addr;
    logic [63:0] data;
    logic [71:0] inj;
    logic        sbe;
    logic        dbe;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{9'd0,   64'h0123456789ABCDEF, 72'h0,                   1'b0, 1'b0},
    '{9'd1,   64'hFFFFFFFFFFFFFFFF, 72'h0,                   1'b0, 1'b0},
    '{9'd2,   64'hDEADBEEFCAFEF00D, 72'h20,                  1'b1, 1'b0},
    '{9'd3,   64'hA5A5A5A55A5A5A5A, 72'h008000000000000000,  1'b1, 1'b0},
    '{9'd4,   64'h0000000000000001, 72'h010000000000000000,  1'b1, 1'b0},
    '{9'd511, 64'h5555555555555555, 72'h800000000000000000,  1'b1, 1'b0},
    '{9'd6,   64'h13579BDF2468ACE0, 72'h3,                   1'b0, 1'b1},
    '{9'd7,   64'h0F0F0F0FF0F0F0F0, 72'h100000000000000400,  1'b0, 1'b1},
    '{9'd8,   64'h7766554433221100, 72'hC00000000000000000,  1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [71:0] wr_inj = '0;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [7:0]  chk_s, chk_f;
  logic [63:0] dat_s, dat_f;
  logic        sbe_s, dbe_s, sbe_f, dbe_f;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  secded_sdp_ram #(.OUT_REG(1'b1)) u_secded_sdp_ram (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_inj(wr_inj), .wr_chk(chk_s),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(dat_s), .rd_sbe(sbe_s), .rd_dbe(dbe_s)
  );

  secded_sdp_ram #(.OUT_REG(1'b0)) u_secded_sdp_ram_fast (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_inj(wr_inj), .wr_chk(chk_f),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(dat_f), .rd_sbe(sbe_f), .rd_dbe(dbe_f)
  );

  // Check bits built by walking codeword positions 1..71
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [7:0] c;
    int k;
    c = '0;
    k = 0;
    for (int q = 1; q < 72; q++) begin
      if ((q & (q - 1)) != 0) begin
        for (int i = 0; i < 7; i++)
          if ((q >> i) & 1) c[i] = c[i] ^ d[k];
        k = k + 1;
      end
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [65:0] act,
                       input logic [65:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_read(input string req, input logic [63:0] d, input logic s,
                          input logic b, input logic [63:0] ed, input logic es,
                          input logic eb);
    check({d, s, b} == {ed, es, eb}, req, {d, s, b}, {ed, es, eb});
    check(!(s && b), "R10", {64'h0, s, b}, 66'h0);
  endtask

  initial begin
    logic [63:0] prev_d;
    logic        prev_s, prev_b;
    prev_d = '0; prev_s = 1'b0; prev_b = 1'b0;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(chk_s == 8'h0 && chk_f == 8'h0, "R9", {58'h0, chk_s}, 66'h0);
    chk_read("R9", dat_s, sbe_s, dbe_s, 64'h0, 1'b0, 1'b0);
    chk_read("R9", dat_f, sbe_f, dbe_f, 64'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Writes with fault masks; R1 R2: wr_chk reflects clean data only
    for (int v = 0; v < NV; v++) begin
      wr_en = 1'b1; wr_addr = VECS[v].addr; wr_data = VECS[v].data; wr_inj = VECS[v].inj;
      @(negedge clk);
      wr_en = 1'b0; wr_inj = '0;
      check(chk_s == ref_chk(VECS[v].data), "R1 R2", {58'h0, chk_s},
            {58'h0, ref_chk(VECS[v].data)});
    end

    // R2: wr_chk holds while wr_en low
    wr_data = 64'hFEDCBA9876543210;
    repeat (2) @(negedge clk);
    check(chk_s == ref_chk(VECS[NV-1].data), "R2", {58'h0, chk_s},
          {58'h0, ref_chk(VECS[NV-1].data)});

    // Read pass then re-read pass (R7)
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < NV; v++) begin
        logic [63:0] ed;
        string req;
        ed = VECS[v].dbe ? (VECS[v].data ^ VECS[v].inj[63:0]) : VECS[v].data;
        if (pass == 1)              req = "R7";
        else if (VECS[v].dbe)       req = "R6";
        else if (VECS[v].sbe && VECS[v].inj[71:64] != 0) req = "R5";
        else if (VECS[v].sbe)       req = "R4";
        else                        req = "R3";
        rd_en = 1'b1; rd_addr = VECS[v].addr;
        @(negedge clk);
        rd_en = 1'b0;
        chk_read(req, dat_f, sbe_f, dbe_f, ed, VECS[v].sbe, VECS[v].dbe);
        // R8: registered output still shows the previous read
        chk_read("R8", dat_s, sbe_s, dbe_s, prev_d, prev_s, prev_b);
        @(negedge clk);
        chk_read(req, dat_s, sbe_s, dbe_s, ed, VECS[v].sbe, VECS[v].dbe);
        prev_d = ed; prev_s = VECS[v].sbe; prev_b = VECS[v].dbe;
      end
    end

    // R8: outputs hold while rd_en stays low, even as the address moves
    rd_addr = 9'd0;
    repeat (3) @(negedge clk);
    chk_read("R8", dat_s, sbe_s, dbe_s, prev_d, prev_s, prev_b);
    chk_read("R8", dat_f, sbe_f, dbe_f, prev_d, prev_s, prev_b);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule